// File: doc/BRIEF.md
# Pulse-Coded Link Receiver with Loss-of-Signal Watchdog

This block is the receive side of one channel of a pulse-coded isolation link. The far side does not send a level. It sends a short "raise" strobe when its input goes high and a short "drop" strobe when its input goes low. It also repeats the strobe for the current level at a steady refresh rate. The receiver rebuilds the level from these strobes and holds it between them. The held value appears on `data_out`.

A watchdog counts clock cycles since the last valid strobe. If the window runs out, the sender is taken to be unpowered or broken. The output then drops to the fail-safe low level and `link_ok` falls. The first valid strobe after that restores `link_ok` and loads the level it carries, on the same clock edge. The watchdog window is a parameter in clock cycles; its default of 1250 cycles is 5 µs at 250 MHz.

A cycle in which both strobes are seen at once breaks the protocol. The held level stays as it was, `proto_err` pulses for one cycle, and the strobe pair does not count as activity for the watchdog.

Top module: `pulse_link_rx`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released with no strobe applied, `data_out`=0, `link_ok`=0 and `proto_err`=0. The watchdog comes out of reset already expired.
- R2: A clock edge with `set_pulse`=1 and `reset_pulse`=0 makes `data_out`=1 from that edge onward.
- R3: A clock edge with `reset_pulse`=1 and `set_pulse`=0 makes `data_out`=0 from that edge onward.
- R4: When no strobe arrives, `data_out` keeps its last value until the watchdog expires.
- R5: Suppose a valid strobe is sampled at edge 0 and none at edges 1 to TIMEOUT_CYC. Then `link_ok` and `data_out` are both 0 after edge TIMEOUT_CYC, and `link_ok` is still 1 after edge TIMEOUT_CYC-1. While `link_ok`=0, `data_out`=0.
- R6: Every valid strobe restarts the watchdog. Strobes spaced exactly TIMEOUT_CYC edges apart keep `link_ok`=1 indefinitely.
- R7: When the watchdog has expired, the first valid strobe raises `link_ok` and loads `data_out` at the same edge.
- R8: A clock edge with both strobes at 1 leaves `data_out` unchanged and makes `proto_err`=1 for exactly the following cycle. It neither restarts the watchdog nor restores `link_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst | input | 1 | Synchronous reset, active high |
| set_pulse | input | 1 | Strobe that marks a rising level (one cycle) |
| reset_pulse | input | 1 | Strobe that marks a falling level (one cycle) |
| data_out | output | 1 | Rebuilt level, forced low while the link is down |
| link_ok | output | 1 | High while valid strobes arrive within the watchdog window |
| proto_err | output | 1 | One-cycle flag after a cycle with both strobes |

## Verification
Alternating raise and drop strobes show that both strobes really move the output. Repeated strobes of the same kind show that the receiver stores a level and does not toggle. Idle gaps shorter than the window check that the level is held. Gaps exactly one cycle short of the window and exactly at the window separate a correct count from an off-by-one. Strobes placed right at the limit show that a strobe wins over expiry on the same edge. Double strobes are placed while the link is up, just before expiry and while the link is down. Together they show that such a strobe pair holds the level and raises the flag, but is never taken as proof that the sender is alive.

// File: rtl/plr_pkg.sv
package plr_pkg;

   typedef enum logic [1:0] {
      EV_IDLE = 2'b00,
      EV_RISE = 2'b01,
      EV_FALL = 2'b10,
      EV_CLASH = 2'b11
   } plr_event_e;

   function automatic logic plr_is_valid(plr_event_e ev);
      return (ev == EV_RISE) || (ev == EV_FALL);
   endfunction

endpackage

// File: rtl/plr_strobe_classify.sv
module plr_strobe_classify
   import plr_pkg::*;
(
   input  logic       rise_i,
   input  logic       fall_i,
   output plr_event_e ev_o,
   output logic       valid_o
);

   always_comb begin
      unique case ({fall_i, rise_i})
         2'b01:   ev_o = EV_RISE;
         2'b10:   ev_o = EV_FALL;
         2'b11:   ev_o = EV_CLASH;
         default: ev_o = EV_IDLE;
      endcase
   end

   assign valid_o = plr_is_valid(ev_o);

endmodule

// File: rtl/plr_watchdog.sv
module plr_watchdog #(
   parameter int unsigned TIMEOUT_CYC = 1250
) (
   input  logic clk,
   input  logic rst,
   input  logic kick_i,
   output logic expired_o,
   output logic expire_now_o
);

   localparam int unsigned CNT_W = (TIMEOUT_CYC < 2) ? 1 : $clog2(TIMEOUT_CYC);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYC - 1);

   generate
      if (TIMEOUT_CYC < 2) begin : g_bad_timeout
         $error("plr_watchdog: TIMEOUT_CYC must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             expired_q;

   assign expire_now_o = !expired_q && !kick_i && (cnt_q == LIMIT);
   assign expired_o    = expired_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q     <= '0;
         expired_q <= 1'b1;
      end else if (kick_i) begin
         cnt_q     <= '0;
         expired_q <= 1'b0;
      end else if (expire_now_o) begin
         cnt_q     <= '0;
         expired_q <= 1'b1;
      end else if (!expired_q) begin
         cnt_q     <= cnt_q + 1'b1;
      end
   end

   // R6: a valid strobe always restarts the window
   a_r6_kick_restarts: assert property (@(posedge clk) disable iff (rst)
      kick_i |=> (cnt_q == '0) && !expired_q);

   // R5: the count never passes the limit
   a_r5_count_bounded: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= LIMIT);

   // R5: expiry only follows a full window
   a_r5_expire_at_limit: assert property (@(posedge clk) disable iff (rst)
      (!expired_q && !kick_i && cnt_q != LIMIT) |=> !expired_q);

endmodule

// File: rtl/plr_level_hold.sv
module plr_level_hold
   import plr_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  plr_event_e ev_i,
   input  logic       drop_i,
   output logic       level_o,
   output logic       clash_o
);

   logic level_q;
   logic clash_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         level_q <= 1'b0;
         clash_q <= 1'b0;
      end else begin
         clash_q <= (ev_i == EV_CLASH);
         unique case (ev_i)
            EV_RISE: level_q <= 1'b1;
            EV_FALL: level_q <= 1'b0;
            default: if (drop_i) level_q <= 1'b0;
         endcase
      end
   end

   assign level_o = level_q;
   assign clash_o = clash_q;

   // R8: a strobe clash keeps the level unless the link drops at that edge
   a_r8_clash_holds: assert property (@(posedge clk) disable iff (rst)
      (ev_i == EV_CLASH && !drop_i) |=> (level_q == $past(level_q)) && clash_q);

   // R4: idle cycles without a drop keep the level
   a_r4_idle_holds: assert property (@(posedge clk) disable iff (rst)
      (ev_i == EV_IDLE && !drop_i) |=> $stable(level_q));

endmodule

// File: rtl/pulse_link_rx.sv
module pulse_link_rx #(
   parameter int unsigned TIMEOUT_CYC = 1250
) (
   input  logic clk,
   input  logic rst,
   input  logic set_pulse,
   input  logic reset_pulse,
   output logic data_out,
   output logic link_ok,
   output logic proto_err
);

   import plr_pkg::*;

   plr_event_e ev;
   logic       ev_valid;
   logic       wd_expired;
   logic       wd_expire_now;

   plr_strobe_classify u_classify (
      .rise_i  (set_pulse),
      .fall_i  (reset_pulse),
      .ev_o    (ev),
      .valid_o (ev_valid)
   );

   plr_watchdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_watchdog (
      .clk          (clk),
      .rst          (rst),
      .kick_i       (ev_valid),
      .expired_o    (wd_expired),
      .expire_now_o (wd_expire_now)
   );

   plr_level_hold u_level (
      .clk     (clk),
      .rst     (rst),
      .ev_i    (ev),
      .drop_i  (wd_expire_now),
      .level_o (data_out),
      .clash_o (proto_err)
   );

   assign link_ok = !wd_expired;

   // R5: a down link always shows the fail-safe low level
   a_r5_down_forces_low: assert property (@(posedge clk) disable iff (rst)
      !link_ok |-> !data_out);

   // R2, R7: a raise strobe loads high and brings the link up
   a_r2_rise_loads: assert property (@(posedge clk) disable iff (rst)
      (set_pulse && !reset_pulse) |=> data_out && link_ok);

   // R3, R7: a drop strobe loads low and brings the link up
   a_r3_fall_loads: assert property (@(posedge clk) disable iff (rst)
      (reset_pulse && !set_pulse) |=> !data_out && link_ok);

   // R8: a clash never revives a down link
   a_r8_clash_no_revive: assert property (@(posedge clk) disable iff (rst)
      (set_pulse && reset_pulse && !link_ok) |=> !link_ok && proto_err);

endmodule

// File: tb/pulse_link_rx_tb.sv
`timescale 1ns/1ps
module pulse_link_rx_tb;

   localparam int TO = 1250;
   localparam realtime HALF = 2.0;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic s_in = 1'b0;
   logic r_in = 1'b0;
   logic d_out, ok_out, err_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(HALF) clk = ~clk;

   pulse_link_rx #(.TIMEOUT_CYC(TO)) u_dut (
      .clk         (clk),
      .rst         (rst),
      .set_pulse   (s_in),
      .reset_pulse (r_in),
      .data_out    (d_out),
      .link_ok     (ok_out),
      .proto_err   (err_out)
   );

   // fields: {set, reset, exp data, exp link_ok, exp proto_err}
   localparam logic [4:0] VEC [12] = '{
      5'b00_000,  // R1 idle after reset: still down
      5'b10_110,  // R7 R2 raise revives and loads high
      5'b00_110,  // R4 hold
      5'b10_110,  // R2 repeated raise stays high
      5'b01_010,  // R3 drop
      5'b01_010,  // R3 repeated drop stays low
      5'b10_110,  // R2
      5'b11_111,  // R8 clash keeps high, flag
      5'b00_110,  // R8 flag lasts one cycle
      5'b01_010,  // R3
      5'b11_011,  // R8 clash keeps low
      5'b10_110   // R2
   };

   task automatic step(input logic s, input logic r);
      s_in = s;
      r_in = r;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [2:0] exp);
      n_chk++;
      if ({d_out, ok_out, err_out} !== exp) begin
         n_bad++;
         $display("FAIL %s: {data,ok,err} actual=%b expected=%b", req, {d_out, ok_out, err_out}, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: bench hung actual=running expected=done");
      finish_run();
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      check("R1", 3'b000);
      rst = 1'b0;
      step(1'b0, 1'b0);
      check("R1", 3'b000);

      for (int k = 0; k < 12; k++) begin
         step(VEC[k][4], VEC[k][3]);
         check($sformatf("vector %0d", k), VEC[k][2:0]);
      end

      // R5 boundary: last vector raised at edge 0
      idle(TO - 1);
      check("R5 edge T-1 still up", 3'b110);
      idle(1);
      check("R5 expiry at edge T", 3'b000);
      idle(5);
      check("R5 down stays low", 3'b000);

      // R8 clash while down
      step(1'b1, 1'b1);
      check("R8 clash no revive", 3'b001);

      // R7 drop strobe revives
      step(1'b0, 1'b1);
      check("R7 drop revives", 3'b010);
      step(1'b1, 1'b0);
      check("R7 R2 load high", 3'b110);

      // R6 strobes exactly TO edges apart
      for (int k = 0; k < 3; k++) begin
         idle(TO - 1);
         check("R6 before refresh", 3'b110);
         step(1'b1, 1'b0);
         check("R6 refresh at limit", 3'b110);
      end

      // R8 clash does not restart watchdog
      idle(TO - 2);
      step(1'b1, 1'b1);
      check("R8 clash at T-1", 3'b111);
      idle(1);
      check("R8 clash ignored by watchdog", 3'b000);

      // R1 reset in mid run
      step(1'b1, 1'b0);
      check("R2 before reset", 3'b110);
      rst = 1'b1;
      step(1'b1, 1'b0);
      check("R1 reset overrides", 3'b000);
      rst = 1'b0;
      step(1'b0, 1'b0);
      check("R1 after reset", 3'b000);

      finish_run();
   end

endmodule